// File: doc/BRIEF.md
# PHY Register Handshake Master

This block lets a simple command port read and write the 16-bit internal registers of a PHY that are not reachable by memory-mapped access. The only path into the PHY is a 20-bit control word that the block drives and a 17-bit status word that comes back. The status word carries an acknowledge flag and 16 bits of read data. Each access is a fixed chain of capture and strobe steps. Every step that raises a capture or strobe bit must see the acknowledge rise, and every step that lowers it must see the acknowledge fall.

A client presents a request with a valid/ready handshake: the direction, a 16-bit register address and, for writes, 16 bits of data. The sequencer then runs the address phase. For a write it continues with data capture and the write strobe. For a read it uses the read strobe. The status word is resynchronised through a flop chain and sampled once every POLL_INTERVAL cycles. No more than MAX_POLLS samples are taken per wait. When the access ends, the block gives a one-cycle done pulse, and an error flag marks an acknowledge timeout.

Top module: `phyreg_hs_master`

## Requirements
- R1: The control word places the 16-bit address or data value in bits 15:0, capture-address in bit 16, capture-data in bit 17, write strobe in bit 18 and read strobe in bit 19; at most one of bits 19:16 is ever set.
- R2: The status word carries the acknowledge in bit 16 and read data in bits 15:0.
- R3: Every access starts by driving the address alone, then the address with capture-address, waiting for acknowledge high, then the address alone, waiting for acknowledge low.
- R4: A write then drives the data alone, then the data with capture-data, waits for acknowledge high, drives the data alone and waits for acknowledge low.
- R5: A write finishes by driving only the write strobe, waiting for acknowledge high, then driving the data alone and waiting for acknowledge low; the PHY register then holds the data.
- R6: A read, after the address phase, drives only the read strobe and waits for acknowledge high. It captures status bits 15:0, drives an all-zero control word and waits for acknowledge low. The captured value appears on the read data output with the done pulse.
- R7: Acknowledge is sampled once every POLL_INTERVAL cycles. A wait that sees the wrong level on MAX_POLLS samples in a row ends as a timeout, so a timeout at the first wait comes no sooner than MAX_POLLS*POLL_INTERVAL cycles after acceptance.
- R8: On timeout the control word goes to zero, error and done are high together for one cycle, the block returns to idle, and the read data output keeps its previous value.
- R9: A request is accepted only while ready is high, which is only in idle. Requests presented while busy are not taken and reach the PHY neither before nor after.
- R10: While waiting for an acknowledge level, the control word holds steady.
- R11: Synchronous active-high reset leaves the block idle, with ready high, done low and the control word zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| ctrl_word | output | 20 | Control word toward the PHY |
| stat_word | input | 17 | Status word from the PHY (acknowledge and read data) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Timeout flag, valid with done |
| rsp_rdata | output | 16 | Data of the last successful read |

## Verification
Random writes and reads to random addresses run against a PHY model whose acknowledge latency changes per access. Comparing the recorded chain of control words with the expected chain shows whether the steps are in the right order. Reading back the data shows whether capture happens at the right acknowledge edge. Two directed cases hold the acknowledge stuck low and stuck high. They separate a timeout on the rising wait from one on the falling wait, and they bound the timeout latency against the poll count. A request held valid through a busy access shows whether commands are wrongly accepted while the block is not idle.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
  localparam int VAL_W       = 16;
  localparam int CTRL_W      = 20;
  localparam int STAT_W      = 17;
  localparam int CAP_ADR_BIT = 16;
  localparam int CAP_DAT_BIT = 17;
  localparam int WR_BIT      = 18;
  localparam int RD_BIT      = 19;
  localparam int ACK_BIT     = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_SET, ST_A_CAP, ST_A_REL,
    ST_D_SET, ST_D_CAP, ST_D_REL,
    ST_W_STB, ST_W_REL,
    ST_R_STB, ST_R_REL
  } step_e;

  function automatic logic [CTRL_W-1:0] mk_word(input logic [VAL_W-1:0] v,
                                                input logic ca, input logic cd,
                                                input logic wr, input logic rd);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[VAL_W-1:0]  = v;
    w[CAP_ADR_BIT] = ca;
    w[CAP_DAT_BIT] = cd;
    w[WR_BIT]      = wr;
    w[RD_BIT]      = rd;
    return w;
  endfunction
endpackage

// File: rtl/phyreg_sync.sv
module phyreg_sync #(
  parameter int W      = 17,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/phyreg_ack_poll.sv
module phyreg_ack_poll #(
  parameter int POLL_INTERVAL = 4,
  parameter int MAX_POLLS     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic expect_lvl,
  input  logic ack,
  output logic hit,
  output logic tmo
);
  localparam int TW = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL) : 1;
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(POLL_INTERVAL - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  logic          active;
  logic          exp_q;
  logic [TW-1:0] tick_q;
  logic [PW-1:0] polls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      exp_q   <= 1'b0;
      tick_q  <= '0;
      polls_q <= '0;
      hit     <= 1'b0;
      tmo     <= 1'b0;
    end else begin
      hit <= 1'b0;
      tmo <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        exp_q   <= expect_lvl;
        tick_q  <= '0;
        polls_q <= '0;
      end else if (active) begin
        if (tick_q == TICK_LAST) begin
          tick_q <= '0;
          if (ack == exp_q) begin
            hit    <= 1'b1;
            active <= 1'b0;
          end else if (polls_q == POLL_LAST) begin
            tmo    <= 1'b1;
            active <= 1'b0;
          end else begin
            polls_q <= polls_q + 1'b1;
          end
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end
    end
  end

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    polls_q <= POLL_LAST);

  // R7
  tmo_after_last_poll_chk: assert property (@(posedge clk) disable iff (rst)
    tmo |-> $past(polls_q) == POLL_LAST);

  // R7
  hit_tmo_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hit && tmo));
endmodule

// File: rtl/phyreg_seq.sv
module phyreg_seq
  import phyreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [VAL_W-1:0]  req_addr,
  input  logic [VAL_W-1:0]  req_wdata,
  input  logic [VAL_W-1:0]  stat_data,
  input  logic              poll_hit,
  input  logic              poll_tmo,
  output logic              poll_start,
  output logic              poll_expect,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [VAL_W-1:0]  rsp_rdata
);
  step_e            state_q;
  logic             wr_q;
  logic [VAL_W-1:0] addr_q;
  logic [VAL_W-1:0] data_q;
  logic [VAL_W-1:0] rd_tmp_q;
  logic             waiting;

  assign req_ready = (state_q == ST_IDLE);
  assign waiting   = (state_q != ST_IDLE) && (state_q != ST_A_SET) &&
                     (state_q != ST_D_SET);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      rd_tmp_q    <= '0;
      ctrl_word   <= '0;
      poll_start  <= 1'b0;
      poll_expect <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_error   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      poll_start <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_error  <= 1'b0;
      if (poll_tmo && waiting) begin
        ctrl_word <= '0;
        rsp_done  <= 1'b1;
        rsp_error <= 1'b1;
        state_q   <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (req_valid) begin
            wr_q      <= req_write;
            addr_q    <= req_addr;
            data_q    <= req_wdata;
            ctrl_word <= mk_word(req_addr, 1'b0, 1'b0, 1'b0, 1'b0);
            state_q   <= ST_A_SET;
          end
          ST_A_SET: begin
            ctrl_word   <= mk_word(addr_q, 1'b1, 1'b0, 1'b0, 1'b0);
            poll_start  <= 1'b1;
            poll_expect <= 1'b1;
            state_q     <= ST_A_CAP;
          end
          ST_A_CAP: if (poll_hit) begin
            ctrl_word   <= mk_word(addr_q, 1'b0, 1'b0, 1'b0, 1'b0);
            poll_start  <= 1'b1;
            poll_expect <= 1'b0;
            state_q     <= ST_A_REL;
          end
          ST_A_REL: if (poll_hit) begin
            if (wr_q) begin
              ctrl_word <= mk_word(data_q, 1'b0, 1'b0, 1'b0, 1'b0);
              state_q   <= ST_D_SET;
            end else begin
              ctrl_word   <= mk_word('0, 1'b0, 1'b0, 1'b0, 1'b1);
              poll_start  <= 1'b1;
              poll_expect <= 1'b1;
              state_q     <= ST_R_STB;
            end
          end
          ST_D_SET: begin
            ctrl_word   <= mk_word(data_q, 1'b0, 1'b1, 1'b0, 1'b0);
            poll_start  <= 1'b1;
            poll_expect <= 1'b1;
            state_q     <= ST_D_CAP;
          end
          ST_D_CAP: if (poll_hit) begin
            ctrl_word   <= mk_word(data_q, 1'b0, 1'b0, 1'b0, 1'b0);
            poll_start  <= 1'b1;
            poll_expect <= 1'b0;
            state_q     <= ST_D_REL;
          end
          ST_D_REL: if (poll_hit) begin
            ctrl_word   <= mk_word('0, 1'b0, 1'b0, 1'b1, 1'b0);
            poll_start  <= 1'b1;
            poll_expect <= 1'b1;
            state_q     <= ST_W_STB;
          end
          ST_W_STB: if (poll_hit) begin
            ctrl_word   <= mk_word(data_q, 1'b0, 1'b0, 1'b0, 1'b0);
            poll_start  <= 1'b1;
            poll_expect <= 1'b0;
            state_q     <= ST_W_REL;
          end
          ST_W_REL: if (poll_hit) begin
            rsp_done <= 1'b1;
            state_q  <= ST_IDLE;
          end
          ST_R_STB: if (poll_hit) begin
            rd_tmp_q    <= stat_data;
            ctrl_word   <= '0;
            poll_start  <= 1'b1;
            poll_expect <= 1'b0;
            state_q     <= ST_R_REL;
          end
          ST_R_REL: if (poll_hit) begin
            rsp_done  <= 1'b1;
            rsp_rdata <= rd_tmp_q;
            state_q   <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl_word[RD_BIT:CAP_ADR_BIT]));

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (waiting && !poll_hit && !poll_tmo) |=> $stable(ctrl_word));

  // R8
  err_zero_word_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_error |-> (rsp_done && ctrl_word == '0 && req_ready));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ctrl_word == '0 && req_ready && !rsp_done));
endmodule

// File: rtl/phyreg_hs_master.sv
module phyreg_hs_master #(
  parameter int POLL_INTERVAL = 4,
  parameter int MAX_POLLS     = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic [19:0] ctrl_word,
  input  logic [16:0] stat_word,
  output logic        rsp_done,
  output logic        rsp_error,
  output logic [15:0] rsp_rdata
);
  import phyreg_pkg::*;

  logic [STAT_W-1:0] stat_sync;
  logic              poll_start;
  logic              poll_expect;
  logic              poll_hit;
  logic              poll_tmo;

  phyreg_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (stat_word),
    .dout (stat_sync)
  );

  phyreg_ack_poll #(.POLL_INTERVAL(POLL_INTERVAL), .MAX_POLLS(MAX_POLLS)) poll_i (
    .clk        (clk),
    .rst        (rst),
    .start      (poll_start),
    .expect_lvl (poll_expect),
    .ack        (stat_sync[ACK_BIT]),
    .hit        (poll_hit),
    .tmo        (poll_tmo)
  );

  phyreg_seq seq_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .stat_data   (stat_sync[VAL_W-1:0]),
    .poll_hit    (poll_hit),
    .poll_tmo    (poll_tmo),
    .poll_start  (poll_start),
    .poll_expect (poll_expect),
    .ctrl_word   (ctrl_word),
    .rsp_done    (rsp_done),
    .rsp_error   (rsp_error),
    .rsp_rdata   (rsp_rdata)
  );
endmodule

// File: tb/phyreg_hs_master_tb_top.sv
module phyreg_hs_master_tb_top;
  localparam int PI = 4;
  localparam int MP = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [19:0] ctrl_word;
  logic [16:0] stat_word = '0;
  logic        rsp_done;
  logic        rsp_error;
  logic [15:0] rsp_rdata;

  always #2 clk = ~clk;

  phyreg_hs_master #(.POLL_INTERVAL(PI), .MAX_POLLS(MP)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .ctrl_word(ctrl_word), .stat_word(stat_word), .rsp_done(rsp_done),
    .rsp_error(rsp_error), .rsp_rdata(rsp_rdata)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // PHY model: delayed view of the control word, acknowledge follows bits 19:16
  logic [19:0] dly [4];
  logic [19:0] prev_tap = '0;
  logic [15:0] pa = '0, pd = '0, pout = '0;
  logic [15:0] phy_mem [256];
  logic [15:0] sb [256];
  int          lat = 0;
  int          stuck = 0;

  always @(posedge clk) begin
    logic [19:0] tap;
    logic        ackv;
    cycles <= cycles + 1;
    dly[0] <= ctrl_word;
    for (int i = 1; i < 4; i++) dly[i] <= dly[i-1];
    tap = (lat == 0) ? ctrl_word : dly[lat-1];
    if (tap[16] && !prev_tap[16]) pa <= tap[15:0];
    if (tap[17] && !prev_tap[17]) pd <= tap[15:0];
    if (tap[18] && !prev_tap[18]) phy_mem[pa[7:0]] <= pd;
    if (tap[19] && !prev_tap[19]) pout <= phy_mem[pa[7:0]];
    prev_tap <= tap;
    ackv = (stuck == 1) ? 1'b0 : (stuck == 2) ? 1'b1 : |tap[19:16];
    stat_word <= {ackv, (tap[19] && prev_tap[19]) ? pout : ~pa};
  end

  // record each distinct control word
  logic [19:0] log_w [32];
  int          log_n = 0;
  logic [19:0] last_ctrl = '0;
  always @(negedge clk) begin
    if (ctrl_word !== last_ctrl) begin
      if (log_n < 32) log_w[log_n] = ctrl_word;
      log_n = log_n + 1;
      last_ctrl = ctrl_word;
    end
  end

  logic [19:0] exp_w [16];
  int          exp_n;

  function automatic void push_exp(input logic [19:0] w, inout logic [19:0] prev);
    if (w != prev) begin
      exp_w[exp_n] = w;
      exp_n++;
      prev = w;
    end
  endfunction

  function automatic void build_exp(input bit wr, input logic [15:0] a,
                                    input logic [15:0] d, input logic [19:0] start);
    logic [19:0] p;
    p = start;
    exp_n = 0;
    push_exp({4'b0000, a}, p);
    push_exp({4'b0001, a}, p);
    push_exp({4'b0000, a}, p);
    if (wr) begin
      push_exp({4'b0000, d}, p);
      push_exp({4'b0010, d}, p);
      push_exp({4'b0000, d}, p);
      push_exp({4'b0100, 16'h0}, p);
      push_exp({4'b0000, d}, p);
    end else begin
      push_exp({4'b1000, 16'h0}, p);
      push_exp(20'h0, p);
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // run one access; returns cycle count from acceptance to done
  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        output int n, output logic err, output logic [15:0] rd);
    int guard;
    guard = 0;
    @(negedge clk);
    while (!req_ready) begin
      @(negedge clk);
      guard++;
      if (guard > 2000) break;
    end
    log_n = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk(1'b0, "R7", "done never seen", 0, 1);
    err = rsp_error;
    rd = rsp_rdata;
  endtask

  task automatic run_checked(input bit wr, input logic [15:0] a, input logic [15:0] d);
    int          n;
    logic        err;
    logic [15:0] rd, rd_before;
    logic [19:0] start_word;
    bit          seq_ok;
    rd_before = rsp_rdata;
    start_word = last_ctrl;
    build_exp(wr, a, d, start_word);
    access(wr, a, d, n, err, rd);
    chk(err == 1'b0, wr ? "R5" : "R6", "unexpected error", err, 0);
    seq_ok = (log_n == exp_n);
    for (int i = 0; i < 16; i++)
      if (seq_ok && i < exp_n && log_w[i] != exp_w[i]) seq_ok = 0;
    chk(seq_ok, wr ? "R4" : "R3", "control word sequence", log_n, exp_n);
    if (wr) begin
      sb[a[7:0]] = d;
      chk(rd == rd_before, "R5", "rdata changed on write", rd, rd_before);
      @(negedge clk);
      chk(phy_mem[a[7:0]] == d, "R5", "PHY register after write", phy_mem[a[7:0]], d);
    end else begin
      chk(rd == sb[a[7:0]], "R6", "read data (R2 status bits 15:0)", rd, sb[a[7:0]]);
    end
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    chk(1'b0, "R7", "watchdog expired", cycles, 150000);
    finish_run();
  end

  initial begin : main
    int          n;
    logic        err;
    logic [15:0] rd, keep;
    bit          busy_ok;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 256; i++) begin
      phy_mem[i] = 16'(i * 16'h3B1 + 16'h11);
      sb[i] = phy_mem[i];
    end
    for (int i = 0; i < 4; i++) dly[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    chk(ctrl_word == 20'h0, "R11", "ctrl after reset", ctrl_word, 0);
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    chk(rsp_done == 1'b0, "R11", "done after reset", rsp_done, 0);

    // directed accesses, R1 R3 R4 R5 R6
    run_checked(1'b1, 16'h0012, 16'hBEEF);
    run_checked(1'b0, 16'h0012, 16'h0000);
    lat = 3;
    run_checked(1'b1, 16'hFFFF, 16'h0000);
    run_checked(1'b0, 16'hFFFF, 16'h0000);
    run_checked(1'b0, 16'h0000, 16'h0000);

    // random mix
    for (int k = 0; k < 40; k++) begin
      lat = int'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1)
        run_checked(1'b1, 16'($urandom), 16'($urandom));
      else
        run_checked(1'b0, 16'($urandom), 16'h0);
    end

    // R9: request held valid while busy is neither taken nor replayed
    lat = 1;
    @(negedge clk);
    log_n = 0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0040; req_wdata = 16'h1234;
    @(negedge clk);
    req_addr = 16'h0041; req_wdata = 16'h9999;
    busy_ok = 1;
    for (int i = 0; i < 20; i++) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(busy_ok, "R9", "ready high while busy", 0, 1);
    n = 0;
    while (!rsp_done && n < 3000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    chk(phy_mem[8'h41] == sb[8'h41], "R9", "held request reached PHY", phy_mem[8'h41], sb[8'h41]);
    chk(phy_mem[8'h40] == 16'h1234, "R9", "accepted write", phy_mem[8'h40], 16'h1234);
    sb[8'h40] = 16'h1234;

    // R7 R8: acknowledge stuck low, timeout on first rising wait
    run_checked(1'b0, 16'h0040, 16'h0);
    keep = rsp_rdata;
    stuck = 1;
    access(1'b0, 16'h0077, 16'h0, n, err, rd);
    chk(err == 1'b1, "R8", "error on stuck-low ack", err, 1);
    chk(ctrl_word == 20'h0, "R8", "ctrl zero after timeout", ctrl_word, 0);
    chk(rd == keep, "R8", "rdata kept on timeout", rd, keep);
    chk(n >= MP * PI && n <= MP * PI + 8, "R7", "timeout latency", n, MP * PI);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R8", "done is one cycle", rsp_done, 0);
    chk(req_ready == 1'b1, "R8", "idle after timeout", req_ready, 1);

    // R7 R8: acknowledge stuck high, timeout on falling wait
    stuck = 2;
    access(1'b1, 16'h0050, 16'h4321, n, err, rd);
    chk(err == 1'b1, "R7", "error on stuck-high ack", err, 1);
    chk(n > MP * PI, "R7", "falling-wait timeout latency", n, MP * PI);
    chk(ctrl_word == 20'h0, "R8", "ctrl zero after second timeout", ctrl_word, 0);
    stuck = 0;
    repeat (8) @(negedge clk);

    // recovery after timeouts
    run_checked(1'b1, 16'h0050, 16'h4321);
    run_checked(1'b0, 16'h0050, 16'h0);

    finish_run();
  end
endmodule